// File: doc/BRIEF.md
# Configuration Image Initializer

This block builds a small word-addressed configuration image whenever the controller it serves goes through a selective reset. A one-cycle start strobe captures the 48-bit station address. The block then writes one word per clock, starting from index zero. The first three words take the station address. One fixed index takes a constant control word. Every other word below the last is written as zero. While it writes, a 16-bit accumulator adds up each value it stores.

Once the last regular word is stored, the block writes the final word. That word is the signature 0xBABA minus the accumulated sum, taken modulo 2^16, so the whole image adds up to the signature. One cycle later it raises a done flag. A serial memory front end reads the image through a combinational word read port. Until the image is complete, that port returns all ones.

Top module: `cfg_image_builder`

## Requirements
- R1: After reset `initDone` is 0 and `rdData` reads 0xFFFF at any address.
- R2: When complete, words 0, 1 and 2 hold `stationAddr[15:0]`, `[31:16]` and `[47:32]`. Address byte 0 (`stationAddr[7:0]`) therefore lands in bits 7:0 of word 0.
- R3: When complete, word index 10 (0xA) holds 0x4000.
- R4: When complete, every word other than 0, 1, 2, 10 and the last one (index DEPTH-1) holds 0x0000.
- R5: The last word equals 0xBABA minus the 16-bit wrapping sum of all other words, so the wrapping sum of all DEPTH words is 0xBABA.
- R6: `initDone` goes high after the (DEPTH+1)-th rising edge that follows the edge sampling `initStart`.
- R7: While an initialization is in progress, `rdData` returns 0xFFFF.
- R8: A start strobe during an initialization restarts the build from index 0 with the newly presented address. Timing is counted from the new strobe.
- R9: The station address is captured on the start strobe. Changes to `stationAddr` after that strobe do not alter the image.
- R10: `initDone` clears on the edge that samples `initStart`. It then stays high from completion until the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initStart | input | 1 | Selective-reset strobe that starts a build |
| stationAddr | input | 48 | Station address, byte 0 in bits 7:0 |
| rdAddr | input | $clog2(DEPTH) | Word index for reads |
| rdData | output | 16 | Word read data, 0xFFFF while no complete image exists |
| initDone | output | 1 | High while a complete image is present |

## Verification
The bench sums every word of the image back and compares the total with the signature. It uses address patterns of all zeros, all ones and random values, so an error in the sign or the wrap of the checksum shows up as a wrong total. It counts the cycles from strobe to done exactly. A controller that writes one word too many or too few, or raises done in the same cycle as the seal write, gives the wrong count. It restarts a build halfway through and changes the address input after the strobe. A design that keeps the old sum, resumes at the old index, or reads the address live would leave a stale or mixed image. It also reads during builds and checks for all ones, which catches a read port that exposes a half-written image.

// File: rtl/cfg_image_pkg.sv
package cfg_image_pkg;

  localparam logic [15:0] IMAGE_SIGNATURE = 16'hBABA;
  localparam int          CTRL_WORD_IDX   = 10;
  localparam logic [15:0] CTRL_WORD_VALUE = 16'h4000;
  localparam logic [15:0] READ_IDLE_VALUE = 16'hFFFF;

  typedef enum logic [1:0] {
    BUILD_IDLE   = 2'd0,
    BUILD_FILL   = 2'd1,
    BUILD_SEAL   = 2'd2,
    BUILD_SETTLE = 2'd3
  } build_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;   // capture address, clear sum and index
    logic fillStep;  // store one regular word and advance
    logic sealStep;  // store the checksum word
  } build_strobe_t;

endpackage

// File: rtl/cfg_image_ctrl.sv
module cfg_image_ctrl
  import cfg_image_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          initStart,
  input  logic          fillAtEnd,
  output build_strobe_t strobe,
  output logic          imageReady
);

  build_state_t state, stateNext;
  logic         readyReg;

  always_comb begin
    stateNext = state;
    case (state)
      BUILD_IDLE:   stateNext = BUILD_IDLE;
      BUILD_FILL:   if (fillAtEnd) stateNext = BUILD_SEAL;
      BUILD_SEAL:   stateNext = BUILD_SETTLE;
      BUILD_SETTLE: stateNext = BUILD_IDLE;
      default:      stateNext = BUILD_IDLE;
    endcase
    if (initStart) stateNext = BUILD_FILL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= BUILD_IDLE;
      readyReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (initStart)
        readyReg <= 1'b0;
      else if (state == BUILD_SETTLE)
        readyReg <= 1'b1;
    end
  end

  always_comb begin
    strobe.restart  = initStart;
    strobe.fillStep = (state == BUILD_FILL) && !initStart;
    strobe.sealStep = (state == BUILD_SEAL) && !initStart;
  end

  assign imageReady = readyReg;

endmodule

// File: rtl/cfg_image_dp.sv
module cfg_image_dp
  import cfg_image_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  build_strobe_t strobe,
  input  logic [47:0]   stationAddr,
  input  logic          imageReady,
  input  logic [AW-1:0] rdAddr,
  output logic [15:0]   rdData,
  output logic          fillAtEnd
);

  localparam logic [AW-1:0] LAST_IDX      = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LAST_FILL_IDX = AW'(DEPTH - 2);

  logic [15:0]   imageMem [DEPTH];
  logic [47:0]   addrLatch;
  logic [15:0]   sumAcc;
  logic [AW-1:0] fillIdx;
  logic [15:0]   fillWord;
  logic [15:0]   sealWord;

  always_comb begin
    if (fillIdx == AW'(0))
      fillWord = addrLatch[15:0];
    else if (fillIdx == AW'(1))
      fillWord = addrLatch[31:16];
    else if (fillIdx == AW'(2))
      fillWord = addrLatch[47:32];
    else if (fillIdx == AW'(CTRL_WORD_IDX))
      fillWord = CTRL_WORD_VALUE;
    else
      fillWord = 16'h0000;
  end

  assign sealWord  = IMAGE_SIGNATURE - sumAcc;
  assign fillAtEnd = (fillIdx == LAST_FILL_IDX) && strobe.fillStep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLatch <= '0;
      sumAcc    <= '0;
      fillIdx   <= '0;
    end else if (strobe.restart) begin
      addrLatch <= stationAddr;
      sumAcc    <= '0;
      fillIdx   <= '0;
    end else if (strobe.fillStep) begin
      sumAcc  <= sumAcc + fillWord;
      fillIdx <= fillIdx + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillStep)
      imageMem[fillIdx] <= fillWord;
    else if (strobe.sealStep)
      imageMem[LAST_IDX] <= sealWord;
  end

  always_comb begin
    if (!imageReady)
      rdData = READ_IDLE_VALUE;
    else if (int'(rdAddr) < DEPTH)
      rdData = imageMem[rdAddr];
    else
      rdData = 16'h0000;
  end

endmodule

// File: rtl/cfg_image_builder.sv
module cfg_image_builder
  import cfg_image_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          initStart,
  input  logic [47:0]   stationAddr,
  input  logic [AW-1:0] rdAddr,
  output logic [15:0]   rdData,
  output logic          initDone
);

  build_strobe_t strobe;
  logic          fillAtEnd;
  logic          imageReady;

  cfg_image_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .initStart  (initStart),
    .fillAtEnd  (fillAtEnd),
    .strobe     (strobe),
    .imageReady (imageReady)
  );

  cfg_image_dp #(.DEPTH(DEPTH), .AW(AW)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .stationAddr (stationAddr),
    .imageReady  (imageReady),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .fillAtEnd   (fillAtEnd)
  );

  assign initDone = imageReady;

endmodule

// File: rtl/cfg_image_checker.sv
module cfg_image_checker #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rstN,
  input logic          initStart,
  input logic [AW-1:0] rdAddr,
  input logic [15:0]   rdData,
  input logic          initDone
);

  // edges since the last sampled start strobe, saturating
  int unsigned sinceStart;

  always_ff @(posedge clk) begin
    if (!rstN)
      sinceStart <= 32'hFFFF_FFFF;
    else if (initStart)
      sinceStart <= 0;
    else if (sinceStart != 32'hFFFF_FFFF)
      sinceStart <= sinceStart + 1;
  end

  assert_idle_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> rdData == 16'hFFFF);

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    initStart |=> !initDone);

  assert_done_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    initDone && !initStart |=> initDone);

  assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> sinceStart == DEPTH + 1);

  assert_done_needs_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> sinceStart != 32'hFFFF_FFFF);

endmodule

bind cfg_image_builder cfg_image_checker #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .initStart (initStart),
  .rdAddr    (rdAddr),
  .rdData    (rdData),
  .initDone  (initDone)
);

// File: tb/cfg_image_builder_tb_top.sv
module cfg_image_builder_tb_top;

  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          initStart = 1'b0;
  logic [47:0]   stationAddr = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [15:0]   rdData;
  logic          initDone;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  cfg_image_builder #(.DEPTH(DEPTH)) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .initStart   (initStart),
    .stationAddr (stationAddr),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .initDone    (initDone)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not complete (got %0d cycles, exp < 150000)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      failures = failures + 1;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input int idx, input logic [47:0] a);
    logic [15:0] s;
    if (idx == 0) return a[15:0];
    if (idx == 1) return a[31:16];
    if (idx == 2) return a[47:32];
    if (idx == 10) return 16'h4000;
    if (idx == DEPTH - 1) begin
      s = a[15:0] + a[31:16] + a[47:32] + 16'h4000;
      return 16'hBABA - s;
    end
    return 16'h0000;
  endfunction

  task automatic pulseStart(input logic [47:0] a);
    @(negedge clk);
    initStart   = 1'b1;
    stationAddr = a;
    @(negedge clk);
    initStart = 1'b0;
    check("R10 start clears done", {31'd0, initDone}, 32'd0);
  endtask

  task automatic waitDone();
    int k = 0;
    while (!initDone && k < 1000) begin
      if (k == 3 || k == DEPTH) begin
        rdAddr = AW'(k % DEPTH);
        #1;
        check("R7 read while busy", {16'd0, rdData}, 32'h0000_FFFF);
      end
      @(negedge clk);
      k++;
    end
    check("R6 done latency", k, DEPTH + 1);
  endtask

  task automatic verifyImage(input logic [47:0] a);
    logic [15:0] total = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rdAddr = AW'(i);
      #1;
      total = total + rdData;
      if (i < 3)
        check("R2 address word", {16'd0, rdData}, {16'd0, expWord(i, a)});
      else if (i == 10)
        check("R3 control word", {16'd0, rdData}, {16'd0, expWord(i, a)});
      else if (i == DEPTH - 1)
        check("R5 checksum word", {16'd0, rdData}, {16'd0, expWord(i, a)});
      else
        check("R4 zero word", {16'd0, rdData}, 32'd0);
    end
    check("R5 image sum", {16'd0, total}, 32'h0000_BABA);
  endtask

  task automatic fullRun(input logic [47:0] a);
    pulseStart(a);
    waitDone();
    verifyImage(a);
  endtask

  initial begin
    logic [47:0] a;
    logic [47:0] b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rdAddr = '0;
    #1;
    check("R1 reset done", {31'd0, initDone}, 32'd0);
    check("R1 reset read", {16'd0, rdData}, 32'h0000_FFFF);
    rdAddr = AW'(DEPTH - 1);
    #1;
    check("R1 reset read last", {16'd0, rdData}, 32'h0000_FFFF);

    // directed corners
    fullRun(48'h0);
    fullRun(48'hFFFF_FFFF_FFFF);
    fullRun(48'h0605_0403_0201);

    // R10: done persists while idle
    repeat (20) @(negedge clk);
    check("R10 done holds", {31'd0, initDone}, 32'd1);
    rdAddr = '0;
    #1;
    check("R10 image held", {16'd0, rdData}, 32'h0000_0201);

    // random addresses
    for (int n = 0; n < 8; n++) begin
      a = {$urandom(), $urandom()};
      fullRun(a);
    end

    // R8: restart mid-build
    a = {$urandom(), $urandom()};
    b = {$urandom(), $urandom()};
    pulseStart(a);
    repeat (10) @(negedge clk);
    check("R8 not done before restart", {31'd0, initDone}, 32'd0);
    pulseStart(b);
    waitDone();
    verifyImage(b);

    // R8: restart right before seal
    pulseStart(a);
    repeat (DEPTH - 2) @(negedge clk);
    pulseStart(b ^ 48'h1234_5678_9ABC);
    waitDone();
    verifyImage(b ^ 48'h1234_5678_9ABC);

    // R9: address change after capture
    a = {$urandom(), $urandom()};
    pulseStart(a);
    stationAddr = ~a;
    waitDone();
    verifyImage(a);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule